// File: doc/BRIEF.md
# Switchback SAR Conversion Sequencer

This block sequences a differential successive-approximation converter. The converter has two binary-weighted capacitor arrays, one on the positive side and one on the negative side. While `sample_o` is high, the analog front end tracks the input. A `start_i` pulse ends tracking. From then on, the block asks the comparator for one decision at a time through `cmp_trig_o`. It accepts each answer on `cmp_valid_i`/`cmp_dec_i` and updates the bottom-plate switch words `sw_p_o` and `sw_n_o` after every decision. In those words each bit is one weighted capacitor, with bit 8 the largest, and 1 selects the high reference.

The switching order keeps the common mode of the comparator close to its starting level:

- **First decision:** it is taken with nothing switched.
- **Downward step:** the largest capacitor on the side judged higher then drops to the low reference.
- **Upward steps:** each later decision lifts the next smaller capacitor on the side judged lower to the high reference.

Only one capacitor moves per decision, and none moves twice. After the tenth decision, the block returns to tracking, restores the tracking switch pattern and presents the result with a one-cycle `done_o`. The comparator, the arrays and the sampling switches sit outside the block. A synchronous state sequencer replaces self-timed delay generation.

Top module: `sar_switchback_ctrl`

## Requirements
- R1: While `sample_o` is 1, `sw_p_o` and `sw_n_o` both equal 9'h100: the largest capacitor is at the high reference and all others are at the low reference.
- R2: A `start_i` seen while tracking makes `sample_o` 0 and `cmp_trig_o` 1 at the next edge. This first trigger is issued with both switch words still at 9'h100.
- R3: While converting, `cmp_valid_i` is accepted only in a cycle where `cmp_trig_o` is 0. Each accepted decision is stored for its bit, from bit 9 down to bit 0. Every accepted decision except the tenth produces a one-cycle `cmp_trig_o` at the next edge.
- R4: When the first decision (bit 9) is 1, `sw_p_o[8]` falls to 0. When it is 0, `sw_n_o[8]` falls to 0. No other switch bit changes.
- R5: When the decision for bit k (k = 8..1) is 1, `sw_n_o[k-1]` rises to 1. When it is 0, `sw_p_o[k-1]` rises to 1. No other switch bit changes.
- R6: During a conversion, at most one switch bit changes per cycle, and a switch bit that has left its tracking value does not return before tracking resumes.
- R7: At the edge that accepts the tenth decision, `sample_o` returns to 1, `done_o` pulses for one cycle and `code_o` takes the ten decisions, with the first one in bit 9. `code_o` holds until the next conversion ends. A decision of 1 means the positive input was judged higher.
- R8: `start_i` has no effect while converting, and `cmp_valid_i` has no effect while tracking.
- R9: While `rst_n` is 0, `sample_o` is 1, `cmp_trig_o` and `done_o` are 0, `code_o` is 0 and both switch words are 9'h100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Ends tracking and begins a conversion |
| cmp_valid_i | input | 1 | Comparator decision strobe |
| cmp_dec_i | input | 1 | Comparator decision, 1 when the positive side is higher |
| sample_o | output | 1 | Tracking enable for the sampling switches |
| cmp_trig_o | output | 1 | One-cycle request for a comparison |
| sw_p_o | output | 9 | Positive-array switch word, 1 = high reference |
| sw_n_o | output | 9 | Negative-array switch word, 1 = high reference |
| code_o | output | 10 | Last conversion result |
| done_o | output | 1 | One-cycle pulse when `code_o` updates |

## Verification
The assertions assume that the comparator answers each trigger with exactly one strobe, in a later cycle, and never strobes while a trigger is outstanding. They also assume that `start_i` is only meaningful while tracking. The bench's comparator model keeps to this. It waits one cycle after each trigger, then drives a single strobe whose decision comes from an ideal differential charge model of the current switch words. It injects stray strobes only while tracking and stray starts only in the middle of a conversion. It sweeps every half-LSB-offset input level across the full range, so that the expected code is the input level plus 512.

// File: rtl/sar_sb_pkg.sv
package sar_sb_pkg;

    typedef enum logic {
        PH_TRACK = 1'b0,
        PH_CONV  = 1'b1
    } phase_e;

endpackage

// File: rtl/sar_sb_seq.sv
module sar_sb_seq
    import sar_sb_pkg::*;
#(
    parameter int NBITS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cmp_valid_i,
    output logic             sample_o,
    output logic             trig_o,
    output logic [NBITS-1:0] bit_o,
    output logic             accept_o,
    output logic             done_o
);

    localparam logic [NBITS-1:0] TOP_BIT = {1'b1, {(NBITS-1){1'b0}}};

    typedef struct packed {
        phase_e           ph;
        logic             trig;
        logic [NBITS-1:0] bit_oh;
        logic             done;
    } seq_t;

    seq_t q, d;
    logic accept;

    always_comb begin
        d        = q;
        d.trig   = 1'b0;
        d.done   = 1'b0;
        accept   = 1'b0;
        unique case (q.ph)
            PH_TRACK: begin
                if (start_i) begin
                    d.ph     = PH_CONV;
                    d.trig   = 1'b1;
                    d.bit_oh = TOP_BIT;
                end
            end
            PH_CONV: begin
                if (!q.trig && cmp_valid_i) begin
                    accept = 1'b1;
                    if (q.bit_oh[0]) begin
                        d.ph     = PH_TRACK;
                        d.bit_oh = '0;
                        d.done   = 1'b1;
                    end else begin
                        d.bit_oh = q.bit_oh >> 1;
                        d.trig   = 1'b1;
                    end
                end
            end
            default: d = q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ph: PH_TRACK, trig: 1'b0, bit_oh: '0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sample_o = (q.ph == PH_TRACK);
    assign trig_o   = q.trig;
    assign bit_o    = q.bit_oh;
    assign accept_o = accept;
    assign done_o   = q.done;

    AST_BIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q.bit_oh)); // R3
    AST_TRIG_ONLY_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        q.trig |-> (q.ph == PH_CONV && q.bit_oh != '0)); // R2
    AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.trig |=> !q.trig); // R3
    AST_TRACK_IGNORES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_TRACK && !start_i) |=> (q.ph == PH_TRACK && !q.trig)); // R8

endmodule

// File: rtl/sar_sb_decreg.sv
module sar_sb_decreg #(
    parameter int NBITS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    input  logic             last_i,
    input  logic [NBITS-1:1] bit_i,
    input  logic             dec_i,
    output logic [NBITS-1:1] taken_o,
    output logic [NBITS-1:1] dec_o,
    output logic [NBITS-1:0] code_o
);

    typedef struct packed {
        logic [NBITS-1:1] taken;
        logic [NBITS-1:1] dec;
        logic [NBITS-1:0] code;
    } dreg_t;

    dreg_t q, d;

    always_comb begin
        d = q;
        if (accept_i) begin
            if (last_i) begin
                d.code  = {q.dec, dec_i};
                d.taken = '0;
                d.dec   = '0;
            end else begin
                d.taken = q.taken | bit_i;
                d.dec   = q.dec | (bit_i & {(NBITS-1){dec_i}});
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign taken_o = q.taken;
    assign dec_o   = q.dec;
    assign code_o  = q.code;

    AST_TAKEN_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && !last_i) |=> ($countones(q.taken) == $past($countones(q.taken)) + 1)); // R3
    AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept_i && last_i) |=> $stable(q.code)); // R7

endmodule

// File: rtl/sar_sb_swmap.sv
module sar_sb_swmap #(
    parameter int NBITS = 10
) (
    input  logic [NBITS-1:1] taken_i,
    input  logic [NBITS-1:1] dec_i,
    output logic [NBITS-2:0] sw_p_o,
    output logic [NBITS-2:0] sw_n_o
);

    localparam int NCAP = NBITS - 1;

    // Largest capacitor: starts high, the higher side drops after the first decision.
    assign sw_p_o[NCAP-1] = ~(taken_i[NBITS-1] &  dec_i[NBITS-1]);
    assign sw_n_o[NCAP-1] = ~(taken_i[NBITS-1] & ~dec_i[NBITS-1]);

    // Smaller capacitors: start low, the lower side rises after its decision.
    for (genvar c = 0; c < NCAP - 1; c++) begin : g_up
        assign sw_p_o[c] = taken_i[c+1] & ~dec_i[c+1];
        assign sw_n_o[c] = taken_i[c+1] &  dec_i[c+1];
    end

endmodule

// File: rtl/sar_switchback_ctrl.sv
module sar_switchback_ctrl #(
    parameter int NBITS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cmp_valid_i,
    input  logic             cmp_dec_i,
    output logic             sample_o,
    output logic             cmp_trig_o,
    output logic [NBITS-2:0] sw_p_o,
    output logic [NBITS-2:0] sw_n_o,
    output logic [NBITS-1:0] code_o,
    output logic             done_o
);

    localparam int NCAP = NBITS - 1;
    localparam logic [NCAP-1:0] TRACK_PAT = {1'b1, {(NCAP-1){1'b0}}};

    logic [NBITS-1:0] bit_oh;
    logic             accept;
    logic [NBITS-1:1] taken;
    logic [NBITS-1:1] dec;

    sar_sb_seq #(.NBITS(NBITS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .cmp_valid_i (cmp_valid_i),
        .sample_o    (sample_o),
        .trig_o      (cmp_trig_o),
        .bit_o       (bit_oh),
        .accept_o    (accept),
        .done_o      (done_o)
    );

    sar_sb_decreg #(.NBITS(NBITS)) u_decreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .last_i   (bit_oh[0]),
        .bit_i    (bit_oh[NBITS-1:1]),
        .dec_i    (cmp_dec_i),
        .taken_o  (taken),
        .dec_o    (dec),
        .code_o   (code_o)
    );

    sar_sb_swmap #(.NBITS(NBITS)) u_swmap (
        .taken_i (taken),
        .dec_i   (dec),
        .sw_p_o  (sw_p_o),
        .sw_n_o  (sw_n_o)
    );

    AST_TRACK_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> (sw_p_o == TRACK_PAT && sw_n_o == TRACK_PAT)); // R1
    AST_FIRST_UNSWITCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_trig_o && $past(sample_o)) |-> (sw_p_o == TRACK_PAT && sw_n_o == TRACK_PAT)); // R2
    AST_ONE_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_o |-> ($countones({sw_p_o, sw_n_o} ^ $past({sw_p_o, sw_n_o})) <= 1)); // R6
    AST_NO_RESWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_o && !$past(sample_o)) |->
            ((($past(sw_p_o) ^ TRACK_PAT) & ~(sw_p_o ^ TRACK_PAT)) == '0 &&
             (($past(sw_n_o) ^ TRACK_PAT) & ~(sw_n_o ^ TRACK_PAT)) == '0)); // R6
    AST_DONE_ON_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $rose(sample_o)); // R7

endmodule

// File: tb/sar_switchback_ctrl_tb.sv
module sar_switchback_ctrl_tb;

    localparam int NB = 10;
    localparam int NC = NB - 1;
    localparam logic [NC-1:0] RP = 9'h100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cmp_v_q = 1'b0;
    logic spur = 1'b0;
    logic cmp_d = 1'b0;
    wire  cmp_valid = cmp_v_q | spur;

    logic          sample, trig, done;
    logic [NC-1:0] sw_p, sw_n;
    logic [NB-1:0] code;

    int n_chk = 0;
    int n_fail = 0;
    int m_cur = 0;
    int j = 0;
    int j_last = 0;
    int d2 = 0;
    bit pend = 0;
    bit chk = 0;
    logic [NC-1:0] exp_p, exp_n;
    logic [NB-1:0] held;

    always #5 clk = ~clk;

    sar_switchback_ctrl #(.NBITS(NB)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .cmp_valid_i (cmp_valid),
        .cmp_dec_i   (cmp_d),
        .sample_o    (sample),
        .cmp_trig_o  (trig),
        .sw_p_o      (sw_p),
        .sw_n_o      (sw_n),
        .code_o      (code),
        .done_o      (done)
    );

    function automatic int wsum(input logic [NC-1:0] s);
        int t = 0;
        for (int i = 0; i < NC; i++) if (s[i]) t += (1 << i);
        return t;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Ideal differential charge model plus comparator, one cycle of latency.
    initial begin
        forever begin
            @(negedge clk);
            if (chk) begin
                check(sw_p == exp_p && sw_n == exp_n,
                      (j_last == 0) ? "R4" : ((j_last == NB-1) ? "R7" : "R5"),
                      int'({sw_p, sw_n}), int'({exp_p, exp_n}));
                chk = 0;
            end
            cmp_v_q = 1'b0;
            if (pend) begin
                d2 = 2 * m_cur + 1 + 2 * (wsum(sw_p) - wsum(sw_n));
                cmp_d = (d2 > 0);
                cmp_v_q = 1'b1;
                exp_p = sw_p;
                exp_n = sw_n;
                if (j == 0) begin
                    if (cmp_d) exp_p[NC-1] = 1'b0;
                    else       exp_n[NC-1] = 1'b0;
                end else if (j < NB-1) begin
                    if (cmp_d) exp_n[NC-1-j] = 1'b1;
                    else       exp_p[NC-1-j] = 1'b1;
                end else begin
                    exp_p = RP;
                    exp_n = RP;
                end
                j_last = j;
                j = (j == NB-1) ? 0 : j + 1;
                chk = 1;
                pend = 0;
            end
            if (trig) begin
                pend = 1;
                if (j == 0) check(sw_p == RP && sw_n == RP, "R2 first compare unswitched",
                                  int'({sw_p, sw_n}), int'({RP, RP}));
            end
        end
    end

    task automatic convert(input int m, input bit poke);
        bit got;
        got = 0;
        m_cur = m;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!sample && trig, "R2 start", int'({sample, trig}), 1);
        for (int c = 0; c < 100; c++) begin
            @(negedge clk);
            if (done) begin
                got = 1;
                break;
            end
            start = (poke && c == 5);   // R8 stray start mid-conversion
        end
        start = 1'b0;
        check(got, "R7 done seen", int'(got), 1);
        check(sample == 1'b1, "R7 sample back", int'(sample), 1);
        check(int'(code) == m + 512, "R7 code", int'(code), m + 512);
        @(negedge clk);
        check(!done, "R7 done one cycle", int'(done), 0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        check(sample && !trig && !done && code == '0 && sw_p == RP && sw_n == RP,
              "R9 reset state", int'({sample, trig, done}), 4);
        rst_n = 1'b1;
        @(negedge clk);
        check(sw_p == RP && sw_n == RP, "R1 tracking pattern", int'({sw_p, sw_n}), int'({RP, RP}));

        // R8: stray strobe while tracking changes nothing.
        spur = 1'b1;
        cmp_d = 1'b1;
        repeat (2) @(negedge clk);
        spur = 1'b0;
        @(negedge clk);
        check(sample && !trig && !done && sw_p == RP && sw_n == RP,
              "R8 stray strobe", int'({sw_p, sw_n}), int'({RP, RP}));

        for (int m = -512; m < 512; m++) begin
            convert(m, (m % 5) == 0);
        end

        // R7: result holds while tracking, despite a stray strobe.
        held = code;
        spur = 1'b1;
        @(negedge clk);
        spur = 1'b0;
        repeat (3) @(negedge clk);
        check(code == held && sample, "R7 code held", int'(code), int'(held));
        check(sw_p == RP && sw_n == RP, "R1 tracking after run", int'({sw_p, sw_n}), int'({RP, RP}));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule